// File: doc/BRIEF.md
# Prescaled Reference-Compare Timer

A general-purpose timer for a system-tick or profiling source, reached over a simple single-cycle register bus. A 16-bit counter advances on a timer tick that is either every bus clock or every sixteenth bus clock. On each tick the counter is compared with a programmable reference value. A match raises a sticky reference event flag, and, when enabled, a level interrupt.

In restart mode the counter runs from zero up to and including the reference value and then returns to zero. A period is therefore reference+1 ticks, and software loads n-1 to obtain n ticks. In free-run mode a match only raises the flag, and the counter wraps at its own maximum. Software stops the timer before reprogramming it. It then starts the timer again with one mode write that carries every control bit. Enabling restarts the prescaler and the counter from zero. At each tick software clears the event flags by writing ones to them.

Top module: `ref_timer`

## Requirements
- R1: After reset, all four registers read zero and `irq` is low. The registers are: mode (address 0), reference (address 1), counter (address 2) and events (address 3). Reads are combinational on `bus_addr`.
- R2: Mode bits are: bit 0 run, bit 1 divide-by-16 source, bit 2 restart, bit 3 interrupt enable. With run and restart set, the counter steps 0,1,…,REF and then returns to 0, so each period is REF+1 ticks.
- R3: With bit 1 clear, the counter advances once per clock. With bit 1 set, it advances once per 16 clocks, and the first step comes on the 16th clock after enabling.
- R4: With restart clear, a match sets the reference flag and the counter keeps incrementing. The counter wraps from 0xFFFF to 0.
- R5: While run is 0, the counter and prescaler hold their values and no event flag is set.
- R6: A mode write with run=1 while run is 0 sets the counter and prescaler to 0, so the first period is a full one. A run=1 write while already running does not restart the timer.
- R7: The reference flag is events bit 1. It sets on a tick where the counter equals the reference and stays set. Writing 1 to bit 1 clears it, and writing 0 has no effect.
- R8: A match in the same cycle as a clearing write leaves the reference flag set.
- R9: `irq` is high exactly while the reference flag and the interrupt-enable bit are both 1. Clearing the enable bit drops `irq` and keeps the flag.
- R10: The capture flag (events bit 0) always reads 0. Writing 1 to it has no effect on the other flag.
- R11: The counter register can be read at any time. Writes to address 2 are ignored.
- R12: The reference register is REF_W bits wide and reads back the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write when high, with bus_sel |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 1 | Level interrupt request |

## Verification
The counter-step and wrap properties assume that the reference value and the source select do not change while run is 1. This matches the rule that software stops the timer before reprogramming it. The stimulus follows the same rule: it writes mode 0 before every change of reference or source, and it changes only the run and interrupt-enable bits while the timer runs. Clearing writes land at chosen counter values, one of them on the exact matching tick. This makes the clear/match priority observable.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the reference-compare timer.
// Assumes a word-addressed bus with four register slots.
package tmr_pkg;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_MODE = 2'd0;
    localparam logic [ADDR_W-1:0] A_REF  = 2'd1;
    localparam logic [ADDR_W-1:0] A_CNT  = 2'd2;
    localparam logic [ADDR_W-1:0] A_EVT  = 2'd3;

    localparam int MB_RUN = 0;
    localparam int MB_DIV = 1;
    localparam int MB_RST = 2;
    localparam int MB_IEN = 3;

    localparam int EB_CAP = 0;
    localparam int EB_REF = 1;

    typedef struct packed {
        logic ien;
        logic restart;
        logic div16;
        logic run;
    } mode_t;
endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
// Tick generator: one tick per clock, or one per DIV clocks when the divided
// source is selected. Assumes div_sel is changed only while run is 0.
// The phase restarts from zero on start.
module tmr_prescaler #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic div_sel,
    input  logic start,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase;

    // Advance the divider phase while running from the divided source.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else if (start)
            phase <= '0;
        else if (run && div_sel)
            phase <= (phase == LAST) ? '0 : phase + 1'b1;
    end

    // Tick output: every clock, or once each time the phase wraps.
    always_comb begin
        tick = run && (!div_sel || (phase == LAST));
    end

    // R3: on the divided source two ticks never come back to back
    p_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_sel && run) |=> (!tick || !div_sel));
endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
// Live up-counter with reference compare. In restart mode it returns to zero
// on the matching tick, otherwise it wraps at its maximum. Assumes ref_val
// and restart are stable while ticks occur.
module tmr_counter #(
    parameter int CNT_W = 16,
    parameter int REF_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic             restart,
    input  logic [REF_W-1:0] ref_val,
    output logic [CNT_W-1:0] cnt,
    output logic             match
);
    localparam int CMP_W = (REF_W > CNT_W) ? REF_W : CNT_W;

    // Match pulse: a tick while the counter equals the reference.
    always_comb begin
        match = tick && (CMP_W'(cnt) == CMP_W'(ref_val));
    end

    // Counter update: clear on start, step or wrap on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= '0;
        else if (tick) begin
            if (restart && match)
                cnt <= '0;
            else
                cnt <= cnt + 1'b1;
        end
    end

    // R2: restart mode returns to zero after the matching tick
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (match && restart && !start) |=> (cnt == '0));
    // R4: a non-returning tick increments by one (modulo the width)
    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !start && !(match && restart)) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
    // R5: without a tick the counter holds
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !start) |=> $stable(cnt));
    // R6: enabling starts from zero
    p_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cnt == '0));
endmodule

// File: rtl/tmr_events.sv
`timescale 1ns/1ps
// Sticky reference event flag with write-one-to-clear; a match in the same
// cycle as a clear wins. The capture flag has no source and reads as zero.
module tmr_events (
    input  logic clk,
    input  logic rst_n,
    input  logic match,
    input  logic clr_ref,
    output logic cap_flag,
    output logic ref_flag
);
    // Reference flag: set on match, else cleared by a write of one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ref_flag <= 1'b0;
        else if (match)
            ref_flag <= 1'b1;
        else if (clr_ref)
            ref_flag <= 1'b0;
    end

    // Capture flag: present in the register, never raised.
    always_comb begin
        cap_flag = 1'b0;
    end

    // R8: a match always leaves the flag set
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> ref_flag);
    // R7: a clear without a match empties the flag
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ref && !match) |=> !ref_flag);
    // R7: the flag holds until cleared
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_flag && !clr_ref) |=> ref_flag);
endmodule

// File: rtl/ref_timer.sv
`timescale 1ns/1ps
// Prescaled reference-compare timer, top level. Holds the mode and
// reference registers, decodes the single-cycle bus and muxes read data.
// Assumes REF_W <= 32 and CNT_W <= 32; writes take effect at the clock edge.
module ref_timer #(
    parameter int REF_W = 32,
    parameter int CNT_W = 16,
    parameter int DIV   = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    import tmr_pkg::*;

    mode_t             mode_q;
    logic [REF_W-1:0]  ref_q;
    logic [CNT_W-1:0]  cnt;
    logic              tick, match, start;
    logic              wr_mode, wr_ref, wr_evt, clr_ref;
    logic              cap_flag, ref_flag;

    // Write decode and the disabled-to-enabled start pulse.
    always_comb begin
        wr_mode = bus_sel && bus_wr && (bus_addr == A_MODE);
        wr_ref  = bus_sel && bus_wr && (bus_addr == A_REF);
        wr_evt  = bus_sel && bus_wr && (bus_addr == A_EVT);
        clr_ref = wr_evt && bus_wdata[EB_REF];
        start   = wr_mode && bus_wdata[MB_RUN] && !mode_q.run;
    end

    // Mode register: all control bits written together.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= '0;
        else if (wr_mode)
            mode_q <= mode_t'(bus_wdata[3:0]);
    end

    // Reference register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ref_q <= '0;
        else if (wr_ref)
            ref_q <= bus_wdata[REF_W-1:0];
    end

    tmr_prescaler #(.DIV(DIV)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (mode_q.run),
        .div_sel (mode_q.div16),
        .start   (start),
        .tick    (tick)
    );

    tmr_counter #(.CNT_W(CNT_W), .REF_W(REF_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .start   (start),
        .restart (mode_q.restart),
        .ref_val (ref_q),
        .cnt     (cnt),
        .match   (match)
    );

    tmr_events u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .match    (match),
        .clr_ref  (clr_ref),
        .cap_flag (cap_flag),
        .ref_flag (ref_flag)
    );

    // Read mux, combinational on the address.
    always_comb begin
        case (bus_addr)
            A_MODE:  bus_rdata = BUS_W'(mode_q);
            A_REF:   bus_rdata = BUS_W'(ref_q);
            A_CNT:   bus_rdata = BUS_W'(cnt);
            default: bus_rdata = BUS_W'({ref_flag, cap_flag});
        endcase
    end

    // Level interrupt from the flag gated by its enable.
    always_comb begin
        irq = ref_flag && mode_q.ien;
    end

    // R5: a stopped timer raises no new flag
    p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q.run && !ref_flag && !start) |=> !ref_flag);
    // R11: writes to the counter address leave the reference unchanged
    p_cnt_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == A_CNT) |=> $stable(ref_q));
endmodule

// File: tb/sim_ref_timer.sv
`timescale 1ns/1ps
module sim_ref_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd2;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    always #2 clk = ~clk;   // 250 MHz

    ref_timer u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    int    checks = 0;
    int    errors = 0;
    string tag = "R1";
    bit    finished = 0;

    // behavioural reference model
    bit          m_run, m_div, m_rst, m_ien, m_rf;
    int unsigned m_ref;
    int          m_cnt, m_pre;

    always @(posedge clk) begin
        bit we, tk, mt, st, nrf;
        int nc, np;
        if (!rst_n) begin
            m_run = 0; m_div = 0; m_rst = 0; m_ien = 0; m_rf = 0;
            m_ref = 0; m_cnt = 0; m_pre = 0;
        end else begin
            we = bus_sel && bus_wr;
            tk = m_run && (!m_div || m_pre == 15);
            mt = tk && (int'(m_cnt) == int'(m_ref));
            st = we && bus_addr == 2'd0 && bus_wdata[0] && !m_run;
            np = m_pre; nc = m_cnt;
            if (st) begin
                np = 0; nc = 0;
            end else begin
                if (m_run && m_div) np = (m_pre + 1) % 16;
                if (tk) nc = (m_rst && mt) ? 0 : (m_cnt + 1) % 65536;
            end
            nrf = mt ? 1'b1 : ((we && bus_addr == 2'd3 && bus_wdata[1]) ? 1'b0 : m_rf);
            if (we && bus_addr == 2'd0) {m_ien, m_rst, m_div, m_run} = bus_wdata[3:0];
            if (we && bus_addr == 2'd1) m_ref = bus_wdata;
            m_pre = np; m_cnt = nc; m_rf = nrf;
        end
    end

    task automatic chk(input string t, input longint act, input longint exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(tag, longint'(irq), longint'(m_rf && m_ien), "irq (R9)");
            if (bus_addr == 2'd2)
                chk(tag, longint'(bus_rdata), longint'(m_cnt), "counter (R11)");
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0; bus_addr = 2'd2; bus_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string t);
        @(posedge clk); #1;
        bus_addr = a;
        #0.5;
        chk(t, longint'(bus_rdata), longint'(exp), "read");
        bus_addr = 2'd2;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic wait_cnt(input int v);
        do begin @(posedge clk); #1; end while (m_cnt != v);
    endtask

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #800000;
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog expired in phase %s", tag);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1;

        tag = "R1";
        rd(2'd0, 32'h0, "R1 mode");
        rd(2'd1, 32'h0, "R1 reference");
        rd(2'd2, 32'h0, "R1 counter");
        rd(2'd3, 32'h0, "R1 events");
        chk("R1", longint'(irq), 0, "irq");

        tag = "R12";
        wr(2'd1, 32'h0000_0004);
        rd(2'd1, 32'h4, "R12 reference readback");

        tag = "R2";
        wr(2'd0, 32'hD);            // run, restart, irq enable, direct clock
        idle(40);

        tag = "R7";
        rd(2'd3, 32'h2, "R7 flag set");
        wr(2'd3, 32'h0);
        rd(2'd3, 32'h2, "R7 zero write no effect");
        wait_cnt(0);
        wr(2'd3, 32'h2);
        rd(2'd3, 32'h0, "R7 write one clears");

        tag = "R8";
        wait_cnt(4);                // next edge is the matching tick
        bus_sel = 1; bus_wr = 1; bus_addr = 2'd3; bus_wdata = 32'h2;
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0; bus_addr = 2'd2; bus_wdata = '0;
        rd(2'd3, 32'h2, "R8 match beats clear");

        tag = "R11";
        wr(2'd2, 32'h1234);
        idle(12);
        rd(2'd1, 32'h4, "R11 reference untouched");

        tag = "R5";
        wr(2'd0, 32'h0);
        wr(2'd3, 32'h3);
        idle(30);
        rd(2'd3, 32'h0, "R5 no flag while stopped");

        tag = "R6";
        wr(2'd1, 32'h2);
        wr(2'd0, 32'hF);            // divided source, restart, irq enable
        rd(2'd2, 32'h0, "R6 counter restarted");
        tag = "R3";
        idle(14);
        rd(2'd2, 32'h1, "R3 first divided step");
        idle(200);

        tag = "R4";
        wr(2'd0, 32'h0);
        wr(2'd3, 32'h3);
        wr(2'd1, 32'h3);
        wr(2'd0, 32'h9);            // free run, direct clock, irq enable
        idle(66000);
        rd(2'd3, 32'h2, "R4 flag from free-run match");

        tag = "R6";
        wr(2'd0, 32'h9);            // run already set: no restart
        idle(5);

        tag = "R9";
        wr(2'd0, 32'h1);            // drop interrupt enable only
        chk("R9", longint'(irq), 0, "irq masked");
        rd(2'd3, 32'h2, "R9 flag kept");

        tag = "R10";
        wr(2'd3, 32'h1);
        rd(2'd3, {30'd0, m_rf, 1'b0}, "R10 capture write");
        chk("R10", longint'(bus_rdata[0]), 0, "capture bit");
        idle(10);

        finished = 1;
        summary();
        $finish;
    end
endmodule